// File: doc/BRIEF.md
# Camera Frame Capture to SRAM

This block grabs a single still image from a parallel CMOS image sensor and parks it in an external asynchronous SRAM. The host processor is too slow to keep up with the sensor. The block divides the fast system clock to produce the sensor master clock, which throttles the pixel rate. It samples the sensor's pixel clock, line and frame qualifiers and pixel bus inside the system clock domain. Each accepted pixel becomes one timed SRAM write cycle.

The host requests a capture. Storing starts at the next frame boundary, so a frame that is already in progress is skipped. After the last pixel of the frame is written, the block raises a ready flag and hands the SRAM bus to a small host read port. Each read strobe on that port returns one stored word and then advances the read address. A clear input returns everything to idle so that a new capture can be requested.

Top module: `frame_grab_sram`

## Requirements
- R1: `cam_mclk` is the system clock divided by `DIV` (an even number, default 10). It is high for DIV/2 cycles and low for DIV/2 cycles.
- R2: A `host_start` pulse while idle arms the block. No SRAM write happens until a rising edge of `cam_fv` is seen after arming, so a frame already running when arming occurs is never stored.
- R3: A pixel is taken once per rising edge of `cam_pclk` while both `cam_lv` and `cam_fv` are high. The full `PIX_W`-bit value (default 10 bits) is stored unchanged.
- R4: Each SRAM write places the address and data with `sram_ce_n`/`sram_we_n` high for one cycle. It then drives both strobes low for exactly two cycles and raises them again. Address and data hold steady while `sram_we_n` is low, and a write occupies 5 system cycles, which is less than one pixel period.
- R5: The write address starts at 0 for each capture and rises by one per stored pixel, in raster order (row by row, left to right).
- R6: After exactly `LINE_PIX*FRAME_LINES` writes, `frame_ready` goes to 1 and no further write strobe is issued, whatever the sensor keeps sending.
- R7: While `frame_ready` is 1, `sram_oe_n` and `sram_ce_n` are low, `sram_dq_oe` is 0 and `sram_addr` carries the host read address. While `frame_ready` is 0, `sram_oe_n` is high.
- R8: In the ready state, a `host_rd` pulse loads `host_rdata` with the word at the current read address and pulses `host_rvalid` high for one cycle, one cycle after the strobe. The read address then increments. A `host_rd` while not ready is ignored: no `host_rvalid`, and the read address is unchanged.
- R9: `host_clear` returns the block to idle, drops `frame_ready`, and resets both the write and read addresses to 0. A following capture writes from address 0 and is read back from address 0.
- R10: After reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are 1, and `sram_dq_oe`, `frame_ready` and `host_rvalid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cam_mclk | output | 1 | Divided master clock to the sensor |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_lv | input | 1 | Sensor line-valid qualifier |
| cam_fv | input | 1 | Sensor frame-valid qualifier |
| cam_data | input | PIX_W | Sensor pixel bus |
| host_start | input | 1 | Arm a capture (acted on only when idle) |
| host_clear | input | 1 | Return to idle and reset both addresses |
| host_rd | input | 1 | Read strobe from the host |
| host_rdata | output | PIX_W | Word returned by the last read |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` fresh |
| frame_ready | output | 1 | Frame stored; SRAM owned by the host port |
| sram_addr | output | ADDR_W | SRAM address |
| sram_wdata | output | PIX_W | SRAM write data |
| sram_dq_oe | output | 1 | Enable for the board-level SRAM data drivers |
| sram_rdata | input | PIX_W | SRAM read data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The bench arms the block halfway through a running frame. A design that stores on frame-valid level instead of its rising edge would write a torn image starting at a mid-frame row. It then keeps feeding frames after the store completes, which catches a counter that fails to stop, either because writes spill past the last address or because `frame_ready` rises one pixel early. Frames filled with random values, a ramp and alternating all-ones/all-zeros words are read back through the host port with random gaps, exposing a dropped bit, a skipped or doubled address, or a read address that moves on an ignored strobe. A clear followed by a second capture shows whether either counter fails to return to zero.

// File: rtl/fgrab_pkg.sv
package fgrab_pkg;

  // Capture control sequence
  typedef enum logic [1:0] {
    CT_IDLE,
    CT_ARMED,
    CT_CAPTURE,
    CT_DONE
  } ctl_state_t;

  // One SRAM write cycle, step by step
  typedef enum logic [2:0] {
    WR_IDLE,
    WR_SETUP,
    WR_PULSE_A,
    WR_PULSE_B,
    WR_RELEASE
  } wr_state_t;

endpackage

// File: rtl/fgrab_mclk_div.sv
module fgrab_mclk_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic mclk
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      mclk  <= 1'b0;
    end else if (cnt_q == HALF_LAST) begin
      cnt_q <= '0;
      mclk  <= ~mclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/fgrab_sampler.sv
module fgrab_sampler #(
  parameter int PIX_W = 10,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pclk_i,
  input  logic             lv_i,
  input  logic             fv_i,
  input  logic [PIX_W-1:0] data_i,
  output logic             pix_stb,
  output logic [PIX_W-1:0] pix_data,
  output logic             frame_start
);

  // Stage word layout: {pclk, lv, fv, data}
  localparam int SW = PIX_W + 3;

  logic [SW-1:0] stg [SYNC];
  logic [SW-1:0] tail;
  logic          pclk_prev, fv_prev;
  logic          t_pclk, t_lv, t_fv;

  for (genvar g = 0; g < SYNC; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= {pclk_i, lv_i, fv_i, data_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign tail   = stg[SYNC-1];
  assign t_pclk = tail[SW-1];
  assign t_lv   = tail[SW-2];
  assign t_fv   = tail[SW-3];

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_prev   <= 1'b0;
      fv_prev     <= 1'b0;
      pix_stb     <= 1'b0;
      pix_data    <= '0;
      frame_start <= 1'b0;
    end else begin
      pclk_prev   <= t_pclk;
      fv_prev     <= t_fv;
      pix_stb     <= t_pclk & ~pclk_prev & t_lv & t_fv;
      pix_data    <= tail[PIX_W-1:0];
      frame_start <= t_fv & ~fv_prev;
    end
  end

endmodule

// File: rtl/fgrab_sram_wr.sv
module fgrab_sram_wr
  import fgrab_pkg::*;
#(
  parameter int PIX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             req,
  input  logic [PIX_W-1:0] req_data,
  output logic             done,
  output logic             ce_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic [PIX_W-1:0] wdata
);

  wr_state_t state_q, state_d;
  logic      strobe_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WR_IDLE:    if (req) state_d = WR_SETUP;
      WR_SETUP:   state_d = WR_PULSE_A;
      WR_PULSE_A: state_d = WR_PULSE_B;
      WR_PULSE_B: state_d = WR_RELEASE;
      WR_RELEASE: state_d = WR_IDLE;
      default:    state_d = WR_IDLE;
    endcase
  end

  assign strobe_d = (state_d == WR_PULSE_A) || (state_d == WR_PULSE_B);
  assign done     = (state_q == WR_RELEASE);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= WR_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      wdata   <= '0;
    end else begin
      state_q <= state_d;
      ce_n    <= ~strobe_d;
      we_n    <= ~strobe_d;
      dq_oe   <= (state_d != WR_IDLE);
      if (state_q == WR_IDLE && req) wdata <= req_data;
    end
  end

endmodule

// File: rtl/frame_grab_sram.sv
module frame_grab_sram
  import fgrab_pkg::*;
#(
  parameter int DIV         = 10,
  parameter int PIX_W       = 10,
  parameter int LINE_PIX    = 640,
  parameter int FRAME_LINES = 480,
  parameter int SYNC        = 2,
  localparam int FRAME_PIX  = LINE_PIX * FRAME_LINES,
  localparam int ADDR_W     = $clog2(FRAME_PIX)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cam_mclk,
  input  logic              cam_pclk,
  input  logic              cam_lv,
  input  logic              cam_fv,
  input  logic [PIX_W-1:0]  cam_data,
  input  logic              host_start,
  input  logic              host_clear,
  input  logic              host_rd,
  output logic [PIX_W-1:0]  host_rdata,
  output logic              host_rvalid,
  output logic              frame_ready,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [PIX_W-1:0]  sram_wdata,
  output logic              sram_dq_oe,
  input  logic [PIX_W-1:0]  sram_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_PIX - 1);

  ctl_state_t        state_q;
  logic [ADDR_W-1:0] wr_addr_q, rd_addr_q;
  logic              ready_q;
  logic              pix_stb, frame_start;
  logic [PIX_W-1:0]  pix_data;
  logic              wr_req, wr_done, wr_ce_n;

  fgrab_mclk_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .mclk (cam_mclk)
  );

  fgrab_sampler #(.PIX_W(PIX_W), .SYNC(SYNC)) u_smp (
    .clk         (clk),
    .rst         (rst),
    .pclk_i      (cam_pclk),
    .lv_i        (cam_lv),
    .fv_i        (cam_fv),
    .data_i      (cam_data),
    .pix_stb     (pix_stb),
    .pix_data    (pix_data),
    .frame_start (frame_start)
  );

  assign wr_req = (state_q == CT_CAPTURE) && pix_stb;

  fgrab_sram_wr #(.PIX_W(PIX_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .clr      (host_clear),
    .req      (wr_req),
    .req_data (pix_data),
    .done     (wr_done),
    .ce_n     (wr_ce_n),
    .we_n     (sram_we_n),
    .dq_oe    (sram_dq_oe),
    .wdata    (sram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CT_IDLE;
      wr_addr_q   <= '0;
      rd_addr_q   <= '0;
      ready_q     <= 1'b0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      if (host_clear) begin
        state_q   <= CT_IDLE;
        wr_addr_q <= '0;
        rd_addr_q <= '0;
        ready_q   <= 1'b0;
      end else begin
        unique case (state_q)
          CT_IDLE:  if (host_start) state_q <= CT_ARMED;
          CT_ARMED: if (frame_start) state_q <= CT_CAPTURE;
          CT_CAPTURE: begin
            if (wr_done) begin
              if (wr_addr_q == LAST_ADDR) begin
                state_q <= CT_DONE;
                ready_q <= 1'b1;
              end else begin
                wr_addr_q <= wr_addr_q + 1'b1;
              end
            end
          end
          CT_DONE: begin
            if (host_rd) begin
              host_rdata  <= sram_rdata;
              host_rvalid <= 1'b1;
              rd_addr_q   <= rd_addr_q + 1'b1;
            end
          end
          default: state_q <= CT_IDLE;
        endcase
      end
    end
  end

  // Bus ownership: writer during capture, host port once ready
  assign frame_ready = ready_q;
  assign sram_addr   = ready_q ? rd_addr_q : wr_addr_q;
  assign sram_oe_n   = ~ready_q;
  assign sram_ce_n   = wr_ce_n & ~ready_q;

endmodule

// File: rtl/frame_grab_sram_chk.sv
module frame_grab_sram_chk #(
  parameter int ADDR_W = 19,
  parameter int PIX_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              host_rd,
  input logic              host_clear,
  input logic              host_rvalid,
  input logic              frame_ready,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [PIX_W-1:0]  sram_wdata,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n
);

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |=> !sram_we_n);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_wdata)));

  assert_we_with_ce_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_dq_oe));

  assert_no_write_when_ready_R6: assert property (@(posedge clk) disable iff (rst)
    frame_ready |-> sram_we_n);

  assert_read_owner_R7: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (frame_ready && !sram_dq_oe && !sram_ce_n));

  assert_rvalid_ready_R8: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> frame_ready);

  assert_read_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_ready && $past(frame_ready) && $past(host_rd) && !$past(host_clear))
      |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

  assert_clear_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(host_clear) |-> (!frame_ready && sram_oe_n && sram_we_n));

endmodule

bind frame_grab_sram frame_grab_sram_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/frame_grab_sram_tb.sv
module frame_grab_sram_tb;

  localparam int DIV = 10;
  localparam int PW  = 10;
  localparam int LP  = 16;
  localparam int NL  = 6;
  localparam int FP  = LP * NL;
  localparam int AW  = $clog2(FP);
  localparam int MASK = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cam_mclk, cam_lv = 1'b0, cam_fv = 1'b0;
  logic [PW-1:0] cam_data = '0;
  logic          host_start = 1'b0, host_clear = 1'b0, host_rd = 1'b0;
  logic [PW-1:0] host_rdata;
  logic          host_rvalid, frame_ready;
  logic [AW-1:0] sram_addr;
  logic [PW-1:0] sram_wdata, sram_rdata;
  logic          sram_dq_oe, sram_ce_n, sram_we_n, sram_oe_n;

  always #4 clk = ~clk;

  frame_grab_sram #(.DIV(DIV), .PIX_W(PW), .LINE_PIX(LP), .FRAME_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .cam_mclk(cam_mclk), .cam_pclk(cam_mclk),
    .cam_lv(cam_lv), .cam_fv(cam_fv), .cam_data(cam_data),
    .host_start(host_start), .host_clear(host_clear), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .frame_ready(frame_ready),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_dq_oe(sram_dq_oe),
    .sram_rdata(sram_rdata), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n)
  );

  // Asynchronous SRAM model
  logic [PW-1:0] mem [1 << AW];
  assign sram_rdata = mem[sram_addr];
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_wdata;

  int checks = 0, fails = 0, cyc = 0;
  int wr_count = 0, run = 0;
  logic [AW-1:0] run_addr;
  logic ready_prev = 1'b0;
  int cur_px [FP];
  int exp_px [FP];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  // Write monitor: strobe width, address order, ready timing
  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_we_n) begin
        if (run == 0) begin
          run_addr = sram_addr;
          check(sram_addr == AW'(wr_count), "R5", "write address", int'(sram_addr), wr_count);
        end else begin
          check(sram_addr == run_addr, "R4", "address held", int'(sram_addr), int'(run_addr));
        end
        run++;
      end else if (run > 0) begin
        check(run == 2, "R4", "write strobe width", run, 2);
        wr_count++;
        run = 0;
      end
      if (frame_ready && !ready_prev)
        check(wr_count == FP, "R6", "writes at ready", wr_count, FP);
      ready_prev = frame_ready;
    end
  end

  function automatic int px_val(input int mode, input int idx, input int salt);
    if (mode == 1) return (idx * 37 + salt) & MASK;
    if (mode == 2) return (idx % 2 == 0) ? MASK : 0;
    return int'($urandom) & MASK;
  endfunction

  task automatic send_frame(input int mode, input int salt);
    for (int i = 0; i < FP; i++) cur_px[i] = px_val(mode, i, salt);
    @(negedge cam_mclk) cam_fv = 1'b1;
    repeat (2) @(negedge cam_mclk);
    for (int l = 0; l < NL; l++) begin
      for (int p = 0; p < LP; p++) begin
        @(negedge cam_mclk);
        cam_lv = 1'b1;
        cam_data = PW'(cur_px[l * LP + p]);
      end
      @(negedge cam_mclk);
      cam_lv = 1'b0;
      cam_data = '0;
      @(negedge cam_mclk);
    end
    @(negedge cam_mclk) cam_fv = 1'b0;
    repeat (3) @(negedge cam_mclk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  task automatic host_read(output logic [PW-1:0] d, output logic v);
    @(negedge clk) host_rd = 1'b1;
    @(negedge clk) host_rd = 1'b0;
    d = host_rdata;
    v = host_rvalid;
  endtask

  task automatic read_all(input string req);
    logic [PW-1:0] d;
    logic v;
    int bad = 0;
    for (int i = 0; i < FP; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      host_read(d, v);
      if (!v || int'(d) != exp_px[i]) begin
        bad++;
        check(1'b0, req, $sformatf("readback word %0d", i), int'(d), exp_px[i]);
      end
    end
    check(bad == 0, req, "frame readback mismatches", bad, 0);
  endtask

  initial begin
    logic [PW-1:0] d;
    logic v;
    int hi, lo, keep;
    int seed;
    seed = int'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(sram_ce_n && sram_we_n && sram_oe_n, "R10", "strobes idle high", 0, 1);
    check(!sram_dq_oe && !frame_ready && !host_rvalid, "R10", "flags low", 0, 0);

    // R1 clock division
    while (cam_mclk) @(negedge clk);
    while (!cam_mclk) @(negedge clk);
    hi = 0; while (cam_mclk) begin hi++; @(negedge clk); end
    lo = 0; while (!cam_mclk) begin lo++; @(negedge clk); end
    check(hi == DIV / 2, "R1", "mclk high cycles", hi, DIV / 2);
    check(lo == DIV / 2, "R1", "mclk low cycles", lo, DIV / 2);

    // R8 read while idle ignored
    host_read(d, v);
    check(!v, "R8", "rvalid on idle read", int'(v), 0);

    // R2 arm in the middle of a running frame
    fork
      send_frame(0, 1);
      begin
        repeat (3 * LP * DIV) @(negedge clk);
        pulse(host_start);
      end
    join
    check(wr_count == 0, "R2", "writes from partial frame", wr_count, 0);
    check(!frame_ready, "R2", "ready after partial frame", int'(frame_ready), 0);

    // R3 R5 R6 capture full frame of random values
    send_frame(0, 2);
    for (int i = 0; i < FP; i++) exp_px[i] = cur_px[i];
    repeat (40) @(negedge clk);
    check(frame_ready, "R6", "ready after frame", int'(frame_ready), 1);
    check(wr_count == FP, "R5", "write count", wr_count, FP);

    // R6 extra frame after done is not written
    keep = wr_count;
    send_frame(1, 9);
    check(wr_count == keep, "R6", "writes after done", wr_count, keep);
    // R7 host owns the bus
    check(!sram_oe_n && !sram_ce_n && !sram_dq_oe, "R7", "read ownership", int'(sram_oe_n), 0);
    check(sram_addr == '0, "R7", "read address start", int'(sram_addr), 0);

    // R3 R8 read back with random gaps
    read_all("R8");

    // R9 clear and recapture a ramp frame
    pulse(host_clear);
    check(!frame_ready && sram_oe_n, "R9", "ready after clear", int'(frame_ready), 0);
    wr_count = 0;
    pulse(host_start);
    send_frame(1, 5);
    for (int i = 0; i < FP; i++) exp_px[i] = cur_px[i];
    repeat (40) @(negedge clk);
    check(frame_ready && wr_count == FP, "R9", "recapture count", wr_count, FP);
    read_all("R9");

    // R3 extreme values
    pulse(host_clear);
    wr_count = 0;
    pulse(host_start);
    send_frame(2, 0);
    for (int i = 0; i < FP; i++) exp_px[i] = cur_px[i];
    repeat (40) @(negedge clk);
    check(frame_ready, "R3", "ready on extreme frame", int'(frame_ready), 1);
    read_all("R3");

    summary();
    $finish;
  end

endmodule